// File: doc/BRIEF.md
# Batch-Marking Rank-Ordered Memory Request Scheduler

This block schedules memory requests held in a shared buffer of `NENT` entries. The requests come from `NTHR` threads and target `NBANK` banks. Work is served in batches. When no marked request remains, the scheduler spends a single cycle setting a mark bit on the oldest requests of every thread to every bank, up to a runtime cap. In the same cycle it ranks the threads by how long they are expected to stall, based on the requests just marked. Until the next batch forms, marked requests beat unmarked ones. Among requests of equal mark, row hits come first, then the better-ranked thread, then the oldest request.

The controller behind this block supplies three things each cycle: the open row of each bank, a mask of banks that can accept a command, and at most one new request. The block answers in the same cycle with at most one grant. The granted entry leaves the buffer at the next clock edge, so no bank ever sees two grants in one cycle.

The control is a three-state machine:
- IDLE: no batch is open.
- MARK: the single cycle in which a batch is formed.
- BATCH: requests are being served.

Its transitions are:
- IDLE to MARK: the buffer holds at least one request.
- MARK to BATCH: always, after one cycle.
- BATCH to IDLE: no marked request is left.
- Otherwise the state holds.

Top module: `batch_sched`

## Requirements
- R1: While reset is active and right after it, the buffer is empty, `buf_full` and `grant_valid` are low, the state is IDLE and the marking cap is 5.
- R2: An accepted request goes to the lowest-numbered free entry and receives the next 16-bit arrival number. While all `NENT` entries are occupied, `buf_full` is high and a request offered on `enq_valid` is dropped. An entry freed by a grant can be reused only from the next cycle on.
- R3: From IDLE, the state moves to MARK in the cycle after the buffer is seen non-empty. MARK lasts exactly one cycle and is followed by BATCH. `grant_valid` can be high only in BATCH.
- R4: In the MARK cycle, a valid entry becomes marked if and only if fewer than `cap` older valid entries (lower arrival number) share its thread and its bank.
- R5: An entry written at or after the MARK-cycle edge, including one enqueued during the MARK cycle itself, stays unmarked until a later MARK cycle.
- R6: In the MARK cycle every thread is given a rank, with rank 0 the best. For each thread, its largest per-bank count of newly marked entries is compared first; the lower count ranks better. A tie goes to the thread with fewer marked entries in total, and any remaining tie goes to the lower thread number. The ranks are held until the next MARK cycle.
- R7: Among eligible entries, the grant goes to the first one by this order:
  1. A marked entry beats an unmarked one.
  2. A row hit (the entry's row equals the open row of its bank) beats a miss.
  3. The better-ranked thread wins, using one ranking for all banks.
  4. The lower arrival number wins.
- R8: An entry is eligible when it is valid and its bank's `bank_ready` bit is high. At most one grant is made per cycle, combinationally in the cycle it is chosen. `grant_idx`, `grant_thread`, `grant_bank`, `grant_row` and `grant_marked` describe the granted entry, which is removed at the next clock edge.
- R9: When no marked entry is eligible but an unmarked entry is, the unmarked entry is granted. Banks without marked requests therefore keep working.
- R10: A high `cap_we` loads `cap_wdata` into the cap at the clock edge. The new value takes effect at the next MARK cycle.
- R11: A BATCH cycle that begins with no marked entry goes to IDLE on the next cycle. An unmarked grant is still possible in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_valid | input | 1 | New request offered this cycle |
| enq_thread | input | TW | Thread number of the new request |
| enq_bank | input | BW | Target bank of the new request |
| enq_row | input | ROW_W | Target row of the new request |
| buf_full | output | 1 | All entries occupied; an offered request is dropped |
| open_rows | input | NBANK*ROW_W | Open row of each bank; bank b occupies bits b*ROW_W and up |
| bank_ready | input | NBANK | Bank can accept a command this cycle |
| cap_we | input | 1 | Load a new marking cap |
| cap_wdata | input | CAP_W | New marking cap value |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | IW | Buffer entry granted |
| grant_thread | output | TW | Thread of the granted request |
| grant_bank | output | BW | Bank of the granted request |
| grant_row | output | ROW_W | Row of the granted request |
| grant_marked | output | 1 | Granted request belongs to the current batch |

## Verification
Two events can land in the same cycle: a request arriving, and the scheduler either granting a request or forming a batch. The random stimulus offers a request on most cycles while banks flip between ready and not ready, so arrivals keep coinciding with MARK cycles and with grants. A model inside the bench judges each such cycle. It checks that an arrival during MARK stays unmarked (it later shows up as an unmarked grant). It also checks that the arrival takes the lowest slot that was free before that cycle's dequeue, which the bench sees through `grant_idx` when that entry is granted later.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_BATCH = 2'd2
    } sched_state_e;

endpackage

// File: rtl/batch_mark_unit.sv
module batch_mark_unit #(
    parameter  int NENT  = 16,
    parameter  int NTHR  = 4,
    parameter  int NBANK = 4,
    parameter  int CAP_W = 4,
    parameter  int SEQ_W = 16,
    localparam int TW    = $clog2(NTHR),
    localparam int BW    = $clog2(NBANK),
    localparam int RK_W  = $clog2(NTHR)
) (
    input  logic [NENT-1:0]            valid_i,
    input  logic [NENT-1:0][TW-1:0]    thr_i,
    input  logic [NENT-1:0][BW-1:0]    bank_i,
    input  logic [NENT-1:0][SEQ_W-1:0] seq_i,
    input  logic [CAP_W-1:0]           cap_i,
    output logic [NENT-1:0]            mark_o,
    output logic [NTHR-1:0][RK_W-1:0]  rank_o
);

    localparam int CNT_W = $clog2(NENT + 1);
    localparam int CMP_W = (CAP_W > CNT_W) ? CAP_W : CNT_W;

    // Per entry: count older peers of the same thread and bank (R4)
    for (genvar i = 0; i < NENT; i++) begin : g_ent
        logic [CNT_W-1:0] older;
        always_comb begin
            older = '0;
            for (int j = 0; j < NENT; j++) begin
                if (j != i && valid_i[j] && thr_i[j] == thr_i[i] &&
                    bank_i[j] == bank_i[i] && seq_i[j] < seq_i[i]) begin
                    older = older + CNT_W'(1);
                end
            end
        end
        assign mark_o[i] = valid_i[i] && (CMP_W'(older) < CMP_W'(cap_i));
    end

    // Per thread: worst bank load and total load of the new batch (R6)
    logic [NTHR-1:0][CNT_W-1:0] max_load;
    logic [NTHR-1:0][CNT_W-1:0] tot_load;

    always_comb begin
        logic [CNT_W-1:0] cnt;
        for (int t = 0; t < NTHR; t++) begin
            max_load[t] = '0;
            tot_load[t] = '0;
            for (int b = 0; b < NBANK; b++) begin
                cnt = '0;
                for (int i = 0; i < NENT; i++) begin
                    if (mark_o[i] && thr_i[i] == TW'(t) && bank_i[i] == BW'(b)) begin
                        cnt = cnt + CNT_W'(1);
                    end
                end
                tot_load[t] = tot_load[t] + cnt;
                if (cnt > max_load[t]) begin
                    max_load[t] = cnt;
                end
            end
        end
    end

    // Rank = number of threads that beat this one; 0 is best
    always_comb begin
        for (int t = 0; t < NTHR; t++) begin
            rank_o[t] = '0;
            for (int u = 0; u < NTHR; u++) begin
                if (u != t &&
                    ((max_load[u] < max_load[t]) ||
                     (max_load[u] == max_load[t] && tot_load[u] < tot_load[t]) ||
                     (max_load[u] == max_load[t] && tot_load[u] == tot_load[t] && u < t))) begin
                    rank_o[t] = rank_o[t] + RK_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/batch_pick_unit.sv
module batch_pick_unit #(
    parameter  int NENT  = 16,
    parameter  int NTHR  = 4,
    parameter  int NBANK = 4,
    parameter  int ROW_W = 8,
    parameter  int SEQ_W = 16,
    localparam int TW    = $clog2(NTHR),
    localparam int BW    = $clog2(NBANK),
    localparam int RK_W  = $clog2(NTHR),
    localparam int IW    = $clog2(NENT)
) (
    input  logic [NENT-1:0]             valid_i,
    input  logic [NENT-1:0]             mark_i,
    input  logic [NENT-1:0][TW-1:0]     thr_i,
    input  logic [NENT-1:0][BW-1:0]     bank_i,
    input  logic [NENT-1:0][ROW_W-1:0]  row_i,
    input  logic [NENT-1:0][SEQ_W-1:0]  seq_i,
    input  logic [NTHR-1:0][RK_W-1:0]   rank_i,
    input  logic [NBANK-1:0][ROW_W-1:0] open_rows_i,
    input  logic [NBANK-1:0]            bank_ready_i,
    output logic                        found_o,
    output logic [IW-1:0]               idx_o
);

    localparam int KEY_W = 2 + RK_W + SEQ_W;

    logic [NENT-1:0]            elig;
    logic [NENT-1:0][KEY_W-1:0] key;

    // Larger key wins: mark, hit, inverted rank, inverted age (R7)
    for (genvar i = 0; i < NENT; i++) begin : g_key
        logic hit;
        assign hit     = (row_i[i] == open_rows_i[bank_i[i]]);
        assign elig[i] = valid_i[i] && bank_ready_i[bank_i[i]];
        assign key[i]  = {mark_i[i], hit, ~rank_i[thr_i[i]], ~seq_i[i]};
    end

    always_comb begin
        logic [KEY_W-1:0] best;
        best    = '0;
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NENT; i++) begin
            if (elig[i] && (!found_o || key[i] > best)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                best    = key[i];
            end
        end
    end

endmodule

// File: rtl/batch_sched.sv
module batch_sched
    import sched_pkg::*;
#(
    parameter  int NENT      = 16,
    parameter  int NTHR      = 4,
    parameter  int NBANK     = 4,
    parameter  int ROW_W     = 8,
    parameter  int CAP_W     = 4,
    parameter  int SEQ_W     = 16,
    parameter  int CAP_RESET = 5,
    localparam int TW        = $clog2(NTHR),
    localparam int BW        = $clog2(NBANK),
    localparam int RK_W      = $clog2(NTHR),
    localparam int IW        = $clog2(NENT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enq_valid,
    input  logic [TW-1:0]          enq_thread,
    input  logic [BW-1:0]          enq_bank,
    input  logic [ROW_W-1:0]       enq_row,
    output logic                   buf_full,
    input  logic [NBANK*ROW_W-1:0] open_rows,
    input  logic [NBANK-1:0]       bank_ready,
    input  logic                   cap_we,
    input  logic [CAP_W-1:0]       cap_wdata,
    output logic                   grant_valid,
    output logic [IW-1:0]          grant_idx,
    output logic [TW-1:0]          grant_thread,
    output logic [BW-1:0]          grant_bank,
    output logic [ROW_W-1:0]       grant_row,
    output logic                   grant_marked
);

    sched_state_e state_q, state_d;

    logic [NENT-1:0]             valid_q;
    logic [NENT-1:0]             mark_q;
    logic [NENT-1:0][TW-1:0]     thr_q;
    logic [NENT-1:0][BW-1:0]     bank_q;
    logic [NENT-1:0][ROW_W-1:0]  row_q;
    logic [NENT-1:0][SEQ_W-1:0]  seq_q;
    logic [NTHR-1:0][RK_W-1:0]   rank_q;
    logic [SEQ_W-1:0]            seq_ctr_q;
    logic [CAP_W-1:0]            cap_q;
    logic [NBANK-1:0][ROW_W-1:0] open_rows_a;

    logic [NENT-1:0]             mark_new;
    logic [NTHR-1:0][RK_W-1:0]   rank_new;
    logic                        pick_found;
    logic [IW-1:0]               pick_idx;
    logic                        grant_go;
    logic                        free_found;
    logic [IW-1:0]               free_idx;
    logic                        enq_take;

    assign open_rows_a = open_rows;

    batch_mark_unit #(
        .NENT(NENT), .NTHR(NTHR), .NBANK(NBANK), .CAP_W(CAP_W), .SEQ_W(SEQ_W)
    ) i_mark (
        .valid_i(valid_q),
        .thr_i  (thr_q),
        .bank_i (bank_q),
        .seq_i  (seq_q),
        .cap_i  (cap_q),
        .mark_o (mark_new),
        .rank_o (rank_new)
    );

    batch_pick_unit #(
        .NENT(NENT), .NTHR(NTHR), .NBANK(NBANK), .ROW_W(ROW_W), .SEQ_W(SEQ_W)
    ) i_pick (
        .valid_i     (valid_q),
        .mark_i      (mark_q),
        .thr_i       (thr_q),
        .bank_i      (bank_q),
        .row_i       (row_q),
        .seq_i       (seq_q),
        .rank_i      (rank_q),
        .open_rows_i (open_rows_a),
        .bank_ready_i(bank_ready),
        .found_o     (pick_found),
        .idx_o       (pick_idx)
    );

    // Lowest free slot (R2)
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < NENT; i++) begin
            if (!valid_q[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    assign buf_full = &valid_q;
    assign enq_take = enq_valid && free_found;
    assign grant_go = (state_q == ST_BATCH) && pick_found;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state (R3, R11)
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = (|valid_q) ? ST_MARK : ST_IDLE;
            ST_MARK:  state_d = ST_BATCH;
            ST_BATCH: state_d = (|mark_q) ? ST_BATCH : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        grant_valid  = grant_go;
        grant_idx    = pick_idx;
        grant_thread = thr_q[pick_idx];
        grant_bank   = bank_q[pick_idx];
        grant_row    = row_q[pick_idx];
        grant_marked = mark_q[pick_idx];
    end

    // Control state of the buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= '0;
            mark_q    <= '0;
            rank_q    <= '0;
            seq_ctr_q <= '0;
            cap_q     <= CAP_W'(CAP_RESET);
        end else begin
            if (state_q == ST_MARK) begin
                mark_q <= mark_new;
                rank_q <= rank_new;
            end
            if (grant_go) begin
                valid_q[pick_idx] <= 1'b0;
                mark_q[pick_idx]  <= 1'b0;
            end
            if (enq_take) begin
                valid_q[free_idx] <= 1'b1;
                mark_q[free_idx]  <= 1'b0;
                seq_ctr_q         <= seq_ctr_q + SEQ_W'(1);
            end
            if (cap_we) begin
                cap_q <= cap_wdata;
            end
        end
    end

    // Request payload, no reset needed
    always_ff @(posedge clk) begin
        if (enq_take) begin
            thr_q[free_idx]  <= enq_thread;
            bank_q[free_idx] <= enq_bank;
            row_q[free_idx]  <= enq_row;
            seq_q[free_idx]  <= seq_ctr_q;
        end
    end

    // Checks next to the logic they guard
    logic [NENT-1:0] ent_ready;
    for (genvar i = 0; i < NENT; i++) begin : g_rdy
        assign ent_ready[i] = bank_ready[bank_q[i]];
    end

    a_r8_ready_bank: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> bank_ready[grant_bank]);

    a_r8_live_entry: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> valid_q[grant_idx]);

    a_r3_mark_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MARK) |-> (mark_q == '0));

    a_r5_no_new_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BATCH) |=> ($countones(mark_q) <= $past($countones(mark_q))));

    a_r9_marked_first: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !grant_marked) |-> ((mark_q & valid_q & ent_ready) == '0));

    a_r11_batch_end: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BATCH && mark_q == '0) |=> (state_q == ST_IDLE));

endmodule

// File: tb/test_batch_sched.sv
`timescale 1ns/1ps
module test_batch_sched;

    localparam int NENT  = 16;
    localparam int NTHR  = 4;
    localparam int NBANK = 4;
    localparam int ROW_W = 8;
    localparam int CAP_W = 4;
    localparam int TW    = 2;
    localparam int BW    = 2;
    localparam int IW    = 4;

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   enq_valid;
    logic [TW-1:0]          enq_thread;
    logic [BW-1:0]          enq_bank;
    logic [ROW_W-1:0]       enq_row;
    logic                   buf_full;
    logic [NBANK*ROW_W-1:0] open_rows;
    logic [NBANK-1:0]       bank_ready;
    logic                   cap_we;
    logic [CAP_W-1:0]       cap_wdata;
    logic                   grant_valid;
    logic [IW-1:0]          grant_idx;
    logic [TW-1:0]          grant_thread;
    logic [BW-1:0]          grant_bank;
    logic [ROW_W-1:0]       grant_row;
    logic                   grant_marked;

    always #2.5 clk = ~clk;

    batch_sched i_batch_sched (
        .clk, .rst_n, .enq_valid, .enq_thread, .enq_bank, .enq_row, .buf_full,
        .open_rows, .bank_ready, .cap_we, .cap_wdata, .grant_valid, .grant_idx,
        .grant_thread, .grant_bank, .grant_row, .grant_marked
    );

    int n_total = 0;
    int n_bad   = 0;

    // Reference model state
    bit m_valid [NENT];
    bit m_mark  [NENT];
    int m_thr   [NENT];
    int m_bank  [NENT];
    int m_row   [NENT];
    int m_seq   [NENT];
    int m_rank  [NTHR];
    int m_state;          // 0 idle, 1 mark, 2 batch
    int m_seqctr;
    int m_cap;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int open_of(input int b);
        return int'(open_rows[b*ROW_W +: ROW_W]);
    endfunction

    function automatic bit better(input int a, input int b);
        bit ha, hb;
        ha = (m_row[a] == open_of(m_bank[a]));
        hb = (m_row[b] == open_of(m_bank[b]));
        if (m_mark[a] != m_mark[b]) return m_mark[a];
        if (ha != hb) return ha;
        if (m_rank[m_thr[a]] != m_rank[m_thr[b]]) return m_rank[m_thr[a]] < m_rank[m_thr[b]];
        return m_seq[a] < m_seq[b];
    endfunction

    function automatic int model_pick();
        int best = -1;
        for (int i = 0; i < NENT; i++) begin
            if (m_valid[i] && bank_ready[m_bank[i]]) begin
                if (best < 0 || better(i, best)) best = i;
            end
        end
        return best;
    endfunction

    function automatic void model_form();
        int mx [NTHR];
        int tt [NTHR];
        bit nm [NENT];
        for (int i = 0; i < NENT; i++) begin
            int c = 0;
            for (int j = 0; j < NENT; j++)
                if (j != i && m_valid[j] && m_thr[j] == m_thr[i] &&
                    m_bank[j] == m_bank[i] && m_seq[j] < m_seq[i]) c++;
            nm[i] = m_valid[i] && (c < m_cap);
        end
        for (int t = 0; t < NTHR; t++) begin
            mx[t] = 0; tt[t] = 0;
            for (int b = 0; b < NBANK; b++) begin
                int c = 0;
                for (int i = 0; i < NENT; i++)
                    if (nm[i] && m_thr[i] == t && m_bank[i] == b) c++;
                tt[t] += c;
                if (c > mx[t]) mx[t] = c;
            end
        end
        for (int t = 0; t < NTHR; t++) begin
            m_rank[t] = 0;
            for (int u = 0; u < NTHR; u++)
                if (u != t && (mx[u] < mx[t] || (mx[u] == mx[t] &&
                    (tt[u] < tt[t] || (tt[u] == tt[t] && u < t))))) m_rank[t]++;
        end
        for (int i = 0; i < NENT; i++) m_mark[i] = nm[i];
    endfunction

    // One cycle: inputs are already driven after a falling edge
    task automatic step(input string tag);
        int  eg;
        int  slot;
        bit  full_pre, anyv, anym;
        #1;
        eg = (m_state == 2) ? model_pick() : -1;
        chk(tag, "grant_valid", int'(grant_valid), int'(eg >= 0));
        if (eg >= 0 && grant_valid) begin
            chk(tag, "grant_idx",    int'(grant_idx),    eg);
            chk(tag, "grant_marked", int'(grant_marked), int'(m_mark[eg]));
            chk(tag, "grant_thread", int'(grant_thread), m_thr[eg]);
            chk(tag, "grant_bank",   int'(grant_bank),   m_bank[eg]);
            chk(tag, "grant_row",    int'(grant_row),    m_row[eg]);
        end
        slot = -1; anyv = 0; anym = 0;
        for (int i = 0; i < NENT; i++) begin
            if (!m_valid[i] && slot < 0) slot = i;
            if (m_valid[i]) anyv = 1;
            if (m_mark[i]) anym = 1;
        end
        full_pre = (slot < 0);
        chk("R2", "buf_full", int'(buf_full), int'(full_pre));
        @(posedge clk);
        if (m_state == 1) model_form();
        if (eg >= 0) begin m_valid[eg] = 0; m_mark[eg] = 0; end
        if (enq_valid && slot >= 0) begin
            m_valid[slot] = 1; m_mark[slot] = 0;
            m_thr[slot] = int'(enq_thread); m_bank[slot] = int'(enq_bank);
            m_row[slot] = int'(enq_row); m_seq[slot] = m_seqctr;
            m_seqctr++;
        end
        if (cap_we) m_cap = int'(cap_wdata);
        case (m_state)
            0: m_state = anyv ? 1 : 0;
            1: m_state = 2;
            default: m_state = anym ? 2 : 0;
        endcase
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; enq_valid = 0; enq_thread = '0; enq_bank = '0; enq_row = '0;
        bank_ready = '0; cap_we = 0; cap_wdata = '0; open_rows = '0;
        repeat (3) @(negedge clk);
        chk("R1", "grant_valid in reset", int'(grant_valid), 0);
        chk("R1", "buf_full in reset",    int'(buf_full),    0);
        for (int i = 0; i < NENT; i++) begin m_valid[i] = 0; m_mark[i] = 0; end
        for (int t = 0; t < NTHR; t++) m_rank[t] = 0;
        m_state = 0; m_seqctr = 0; m_cap = 5;
        rst_n = 1'b1;
    endtask

    task automatic enq_one(input int t, input int b, input int r, input int rdy, input string tag);
        enq_valid = 1; enq_thread = TW'(t); enq_bank = BW'(b); enq_row = ROW_W'(r);
        bank_ready = NBANK'(rdy);
        step(tag);
        enq_valid = 0;
    endtask

    task automatic idle_cycles(input int n, input int rdy, input string tag);
        for (int k = 0; k < n; k++) begin
            enq_valid = 0; bank_ready = NBANK'(rdy);
            step(tag);
        end
    endtask

    task automatic rand_cycles(input int n, input int enq_pct, input int rdy_pct, input string tag);
        for (int k = 0; k < n; k++) begin
            enq_valid  = ($urandom_range(99, 0) < enq_pct);
            enq_thread = TW'($urandom_range(NTHR - 1, 0));
            enq_bank   = BW'($urandom_range(NBANK - 1, 0));
            enq_row    = ROW_W'($urandom_range(3, 0));
            for (int b = 0; b < NBANK; b++) begin
                bank_ready[b] = ($urandom_range(99, 0) < rdy_pct);
                open_rows[b*ROW_W +: ROW_W] = ROW_W'($urandom_range(3, 0));
            end
            step(tag);
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1: outputs after reset, default cap of 5 seen on a deep queue
        chk("R1", "grant_valid after reset", int'(grant_valid), 0);
        chk("R1", "buf_full after reset",    int'(buf_full),    0);
        enq_one(0, 3, 0, 4'b0000, "R3");
        enq_one(1, 0, 1, 4'b0000, "R3");
        for (int k = 0; k < 6; k++) enq_one(1, 0, 1, 4'b1000, "R5");
        idle_cycles(4, 4'b1000, "R11");
        idle_cycles(3, 4'b0000, "R3");
        open_rows = '0; open_rows[0 +: ROW_W] = 8'd1;
        idle_cycles(12, 4'b0001, "R1");

        // R6: thread ranking with no row hits anywhere
        do_reset();
        enq_one(0, 3, 9, 4'b0000, "R6");
        enq_one(3, 0, 9, 4'b0000, "R6");
        enq_one(3, 0, 9, 4'b0000, "R6");
        enq_one(3, 0, 9, 4'b0000, "R6");
        enq_one(3, 1, 9, 4'b0000, "R6");
        enq_one(2, 1, 9, 4'b0000, "R6");
        enq_one(2, 2, 9, 4'b0000, "R6");
        enq_one(1, 2, 9, 4'b0000, "R6");
        enq_one(1, 3, 9, 4'b0000, "R6");
        enq_one(0, 0, 9, 4'b0000, "R6");
        open_rows = {NBANK{8'hFF}};
        idle_cycles(20, 4'b1111, "R6");

        // R2: fill the buffer with every bank blocked, then one more
        do_reset();
        for (int k = 0; k < NENT + 2; k++) enq_one(k % NTHR, k % NBANK, k % 3, 4'b0000, "R2");
        chk("R2", "buf_full when filled", int'(buf_full), 1);
        idle_cycles(NENT + 6, 4'b1111, "R8");

        // R10: cap changes between batches
        do_reset();
        cap_we = 1; cap_wdata = 4'd1;
        step("R10");
        cap_we = 0;
        rand_cycles(400, 70, 50, "R10");
        cap_we = 1; cap_wdata = 4'd0;
        step("R10");
        cap_we = 0;
        rand_cycles(200, 60, 60, "R9");
        cap_we = 1; cap_wdata = 4'd2;
        step("R4");
        cap_we = 0;
        rand_cycles(500, 80, 40, "R4");

        // Default cap, assorted load and readiness
        do_reset();
        rand_cycles(800, 60, 70, "R7");
        rand_cycles(600, 90, 30, "R5");
        rand_cycles(400, 20, 90, "R11");
        rand_cycles(400, 95, 15, "R9");

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule